// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the register face of one bus-master DMA channel for a disk-style controller. Host software reaches three registers through a small little-endian register bus. The command register holds a run bit and a transfer direction. The status register shows whether the channel is running, whether it stopped on an error and whether the device raised an interrupt. The table base register holds the address of the descriptor list in memory. Accesses can be one, two or four bytes wide at any byte offset.

From the command register the block produces a one-cycle kick toward the descriptor walker. It also produces the current descriptor pointer and the direction level. It takes back from the walker a "transfer in flight" level and pulses for normal completion and for underrun. The run bit acts only on its edges. When software clears it while a transfer is in flight, the channel waits for the in-flight transfer to drain instead of aborting it. The device interrupt line reaches the host one cycle later, and its rising edge is latched into the status register.

Top module: `bmdma_regs`

## Requirements
- R1: A write to the command register (`reg_sel`=0) stores only bit 0 (run) and bit 3 (direction, also driven on `xfer_dir`). Every other bit of the command register reads back as zero.
- R2: A command write whose bit 0 equals the stored run bit does not pulse `walk_kick` and does not change `desc_ptr` or the active status bit. It may still update the direction bit.
- R3: A command write that takes the run bit from 0 to 1 loads `desc_ptr` with the table base in the cycle after the write. If the channel is not active after that cycle's walker events, the same write also sets the active bit (status bit 0) and pulses `walk_kick` for exactly one cycle. If the channel stays active, there is no kick.
- R4: A command write that takes the run bit from 1 to 0 clears the active bit in the next cycle when `xfer_busy` is low. When `xfer_busy` is high, the active bit stays set as long as `xfer_busy` stays high. It clears in the cycle after `xfer_busy` falls.
- R5: A write to the table base (`reg_sel`=2) replaces only the byte lanes from `reg_off` up to `reg_off`+width-1, capped at lane 3. The width is 1 byte for `reg_size`=0, 2 bytes for 1, and 4 bytes for 2 or 3. Lane `reg_off`+k takes byte k of `reg_wdata`. Bits 1:0 of the base always read as zero.
- R6: A read of the table base returns the base shifted right by 8×`reg_off` bits and masked to the access width. A read of the command or status register returns that byte zero-extended.
- R7: `host_irq` equals `dev_irq` delayed by one cycle. A rising edge of `dev_irq` sets the interrupt status bit (bit 2). A falling edge leaves the status unchanged.
- R8: Writing status (`reg_sel`=1) with a 1 in bit 1 clears the error bit, and a 1 in bit 2 clears the interrupt bit. Bit 0 (active) is unaffected by status writes. If a status write and a rising device interrupt land in the same cycle, the interrupt bit ends up set.
- R9: A `walk_done` pulse clears the active bit. A `walk_underrun` pulse clears the active bit and sets the error bit (status bit 1).
- R10: While `rst_n` is low, the command, status and table base registers, `desc_ptr`, `walk_kick` and `host_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 status, 2 table base |
| reg_off | input | 2 | Byte offset of the access |
| reg_size | input | 2 | Access width: 0 byte, 1 word, 2 or 3 dword |
| reg_wdata | input | 32 | Write data, low byte first |
| reg_rdata | output | 32 | Read data for the selected register, offset and width |
| xfer_busy | input | 1 | Walker has a transfer in flight |
| walk_done | input | 1 | Walker finished the descriptor list |
| walk_underrun | input | 1 | Walker ran out of descriptors before the device finished |
| walk_kick | output | 1 | One-cycle pulse that starts the walker |
| desc_ptr | output | 32 | Current descriptor pointer for the walker |
| xfer_dir | output | 1 | Direction bit from the command register |
| dev_irq | input | 1 | Interrupt level from the device |
| host_irq | output | 1 | Interrupt level toward the host |

## Verification
The hardest state to reach from the ports is a stop request held pending behind an in-flight transfer, and then cut across by a new run edge before the transfer drains. The bench raises `xfer_busy`, clears the run bit and checks that the active bit stays set over several cycles. It then sets the run bit again while the stop is still pending and checks for no kick and for a reloaded pointer. A separate pass lets the stop drain on the falling edge of `xfer_busy`. The byte-lane behaviour of the table base is swept over every width and offset pair, with the expected value built lane by lane.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned LANES  = REG_W / 8;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STS  = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [7:0] CMD_KEEP = 8'h09;
  localparam int unsigned CMD_RUN = 0;
  localparam int unsigned CMD_DIR = 3;
  localparam int unsigned ST_ACT  = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_INT  = 2;

  // Bytes covered by an access of the given size code.
  function automatic logic [LANES-1:0] size_lanes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_lanes = LANES'(4'b0001);
      2'd1:    size_lanes = LANES'(4'b0011);
      default: size_lanes = {LANES{1'b1}};
    endcase
  endfunction

  // Expand a per-lane enable into a bit mask.
  function automatic logic [REG_W-1:0] lanes_to_bits(input logic [LANES-1:0] en);
    logic [REG_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{en[i]}};
    return m;
  endfunction

  // New base value after a partial write; low two bits forced to zero.
  function automatic logic [REG_W-1:0] merge_base(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] wd,
                                                  input logic [1:0] off,
                                                  input logic [1:0] sz);
    logic [REG_W-1:0] m;
    m = lanes_to_bits(size_lanes(sz) << off);
    return ((cur & ~m) | ((wd << {off, 3'b000}) & m)) & ~REG_W'(3);
  endfunction

  // Read view of the base for a given offset and width.
  function automatic logic [REG_W-1:0] view_base(input logic [REG_W-1:0] cur,
                                                 input logic [1:0] off,
                                                 input logic [1:0] sz);
    return (cur >> {off, 3'b000}) & lanes_to_bits(size_lanes(sz));
  endfunction
endpackage

// File: rtl/bmdma_base_reg.sv
module bmdma_base_reg
  import bmdma_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   off,
  input  logic [1:0]   sz,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] base_q,
  output logic [W-1:0] rd_view
);
  always_ff @(posedge clk) begin
    if (!rst_n)     base_q <= '0;
    else if (wr_en) base_q <= merge_base(base_q, wdata, off, sz);
  end

  assign rd_view = view_base(base_q, off, sz);
endmodule

// File: rtl/bmdma_cmd_ctl.sv
module bmdma_cmd_ctl
  import bmdma_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_wr,
  input  logic         sts_wr,
  input  logic [7:0]   wbyte,
  input  logic [W-1:0] base_q,
  input  logic         xfer_busy,
  input  logic         walk_done,
  input  logic         walk_underrun,
  output logic [7:0]   cmd_q,
  output logic         active_q,
  output logic         err_q,
  output logic         stop_pend_q,
  output logic         start_rise,
  output logic         start_fall,
  output logic         kick_q,
  output logic [W-1:0] ptr_q
);
  logic         act_d, err_d, pend_d, kick_d;
  logic [W-1:0] ptr_d;

  assign start_rise = cmd_wr &  wbyte[CMD_RUN] & ~cmd_q[CMD_RUN];
  assign start_fall = cmd_wr & ~wbyte[CMD_RUN] &  cmd_q[CMD_RUN];

  always_comb begin
    act_d  = active_q;
    err_d  = err_q;
    pend_d = stop_pend_q;
    ptr_d  = ptr_q;
    kick_d = 1'b0;
    if (walk_done || walk_underrun) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
    end
    if (walk_underrun) err_d = 1'b1;
    if (stop_pend_q && !xfer_busy) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
    end
    if (sts_wr && wbyte[ST_ERR]) err_d = 1'b0;
    if (start_fall) begin
      if (xfer_busy) pend_d = 1'b1;
      else           act_d  = 1'b0;
    end
    if (start_rise) begin
      ptr_d  = base_q;
      pend_d = 1'b0;
      if (!act_d) begin
        act_d  = 1'b1;
        kick_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      active_q    <= 1'b0;
      err_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      kick_q      <= 1'b0;
      ptr_q       <= '0;
    end else begin
      if (cmd_wr) cmd_q <= wbyte & CMD_KEEP;
      active_q    <= act_d;
      err_q       <= err_d;
      stop_pend_q <= pend_d;
      kick_q      <= kick_d;
      ptr_q       <= ptr_d;
    end
  end
endmodule

// File: rtl/bmdma_irq_fwd.sv
module bmdma_irq_fwd (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_irq,
  input  logic int_clr,
  output logic irq_q,
  output logic int_q,
  output logic irq_rise
);
  assign irq_rise = dev_irq & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      irq_q <= dev_irq;
      if (irq_rise)     int_q <= 1'b1;
      else if (int_clr) int_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [1:0]   reg_sel,
  input  logic [1:0]   reg_off,
  input  logic [1:0]   reg_size,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         xfer_busy,
  input  logic         walk_done,
  input  logic         walk_underrun,
  output logic         walk_kick,
  output logic [W-1:0] desc_ptr,
  output logic         xfer_dir,
  input  logic         dev_irq,
  output logic         host_irq
);
  logic         cmd_wr, sts_wr, base_wr;
  logic [7:0]   cmd_q, sts_byte;
  logic [W-1:0] base_q, base_view;
  logic         active_q, err_q, stop_pend_q, start_rise, start_fall;
  logic         int_q, irq_rise;

  assign cmd_wr  = reg_wr && (reg_sel == SEL_CMD);
  assign sts_wr  = reg_wr && (reg_sel == SEL_STS);
  assign base_wr = reg_wr && (reg_sel == SEL_BASE);

  bmdma_base_reg #(.W(W)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(base_wr), .off(reg_off), .sz(reg_size),
    .wdata(reg_wdata), .base_q(base_q), .rd_view(base_view)
  );

  bmdma_cmd_ctl #(.W(W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .sts_wr(sts_wr),
    .wbyte(reg_wdata[7:0]), .base_q(base_q), .xfer_busy(xfer_busy),
    .walk_done(walk_done), .walk_underrun(walk_underrun), .cmd_q(cmd_q),
    .active_q(active_q), .err_q(err_q), .stop_pend_q(stop_pend_q),
    .start_rise(start_rise), .start_fall(start_fall), .kick_q(walk_kick),
    .ptr_q(desc_ptr)
  );

  bmdma_irq_fwd u_irq (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq),
    .int_clr(sts_wr && reg_wdata[ST_INT]),
    .irq_q(host_irq), .int_q(int_q), .irq_rise(irq_rise)
  );

  assign sts_byte = {5'b0, int_q, err_q, active_q};
  assign xfer_dir = cmd_q[CMD_DIR];

  always_comb begin
    case (reg_sel)
      SEL_CMD:  reg_rdata = W'(cmd_q);
      SEL_STS:  reg_rdata = W'(sts_byte);
      SEL_BASE: reg_rdata = base_view;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_wr,
  input logic [W-1:0] reg_wdata,
  input logic [7:0]   cmd_q,
  input logic [W-1:0] base_q,
  input logic [W-1:0] desc_ptr,
  input logic         active_q,
  input logic         err_q,
  input logic         int_q,
  input logic         stop_pend_q,
  input logic         start_rise,
  input logic         xfer_busy,
  input logic         walk_done,
  input logic         walk_underrun,
  input logic         walk_kick,
  input logic         dev_irq,
  input logic         host_irq
);
  AST_CMD_KEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> cmd_q == ($past(reg_wdata[7:0]) & 8'h09)); // R1

  AST_SAME_RUN_NO_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (reg_wdata[0] == cmd_q[0])) |=> !walk_kick); // R2

  AST_RUN_EDGE_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && !active_q) |=> (walk_kick && active_q && desc_ptr == $past(base_q))); // R3

  AST_KICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_kick |=> !walk_kick); // R3

  AST_STOP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pend_q && xfer_busy && !walk_done && !walk_underrun) |=> active_q); // R4

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[1:0] == 2'b00); // R5

  AST_IRQ_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq) |=> (int_q && host_irq)); // R7

  AST_UNDERRUN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_underrun && !start_rise) |=> (err_q && !active_q)); // R9
endmodule

bind bmdma_regs bmdma_regs_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .reg_wdata(reg_wdata),
  .cmd_q(cmd_q), .base_q(base_q), .desc_ptr(desc_ptr), .active_q(active_q),
  .err_q(err_q), .int_q(int_q), .stop_pend_q(stop_pend_q),
  .start_rise(start_rise), .xfer_busy(xfer_busy), .walk_done(walk_done),
  .walk_underrun(walk_underrun), .walk_kick(walk_kick), .dev_irq(dev_irq),
  .host_irq(host_irq)
);

// File: tb/test_bmdma_regs.sv
module test_bmdma_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [1:0]  reg_off = 2'd0;
  logic [1:0]  reg_size = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_busy = 1'b0;
  logic        walk_done = 1'b0;
  logic        walk_underrun = 1'b0;
  logic        walk_kick;
  logic [31:0] desc_ptr;
  logic        xfer_dir;
  logic        dev_irq = 1'b0;
  logic        host_irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] mdl_base;

  always #5 clk = ~clk;

  bmdma_regs i_bmdma_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_off(reg_off), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xfer_busy(xfer_busy), .walk_done(walk_done),
    .walk_underrun(walk_underrun), .walk_kick(walk_kick), .desc_ptr(desc_ptr),
    .xfer_dir(xfer_dir), .dev_irq(dev_irq), .host_irq(host_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write at a negedge; returns at the following negedge, after the capturing edge.
  task automatic wr(input logic [1:0] sel, input logic [1:0] off,
                    input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_off = off; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] off,
                    input logic [1:0] sz, output logic [31:0] d);
    reg_sel = sel; reg_off = off; reg_size = sz;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] sts(input bit act, input bit err, input bit intr);
    return {29'b0, intr, err, act};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] p;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    // R10 reset state
    rd(2'd0, 0, 2, v); check("R10 cmd", v, 0);
    rd(2'd1, 0, 2, v); check("R10 status", v, 0);
    rd(2'd2, 0, 2, v); check("R10 base", v, 0);
    check("R10 desc_ptr", desc_ptr, 0);
    check("R10 kick", {31'b0, walk_kick}, 0);
    check("R10 host_irq", {31'b0, host_irq}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R5/R6: sweep widths and offsets for writes, all views for reads
    mdl_base = 0;
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 4; off++) begin
        p = 32'h9E37_79B9 * (sz * 4 + off + 1);
        wr(2'd2, off[1:0], sz[1:0], p);
        for (int b = 0; b < 4; b++)
          if (b >= off && b < off + nbytes(sz[1:0])) mdl_base[b*8 +: 8] = p[(b-off)*8 +: 8];
        mdl_base[1:0] = 2'b00;
        rd(2'd2, 0, 2, v); check("R5 base merge", v, mdl_base);
        for (int rs = 0; rs < 3; rs++) begin
          for (int ro = 0; ro < 4; ro++) begin
            exp = 0;
            for (int b = 0; b < nbytes(rs[1:0]); b++)
              if (ro + b < 4) exp[b*8 +: 8] = mdl_base[(ro+b)*8 +: 8];
            rd(2'd2, ro[1:0], rs[1:0], v); check("R6 base view", v, exp);
          end
        end
      end
    end

    // R1: every command byte
    for (int c = 0; c < 256; c++) begin
      wr(2'd0, 0, 0, 32'hFFFF_FF00 | c);
      rd(2'd0, 0, 2, v); check("R1 cmd keep", v, c & 8'h09);
      check("R1 dir pin", {31'b0, xfer_dir}, (c >> 3) & 1);
    end
    wr(2'd0, 0, 0, 0);
    rd(2'd1, 0, 0, v); check("R4 stop idle", v & 1, 0);

    // R3: run edge loads pointer and kicks
    wr(2'd2, 0, 2, 32'h1000_0043);
    wr(2'd0, 0, 0, 32'h1);
    check("R3 kick", {31'b0, walk_kick}, 1);
    check("R3 desc_ptr", desc_ptr, 32'h1000_0040);
    rd(2'd1, 0, 0, v); check("R3 active", v & 1, 1);
    @(negedge clk);
    check("R3 kick one cycle", {31'b0, walk_kick}, 0);

    // R2: same run bit, new base, new direction
    wr(2'd2, 0, 2, 32'h2222_0000);
    wr(2'd0, 0, 0, 32'h9);
    check("R2 no kick", {31'b0, walk_kick}, 0);
    check("R2 ptr held", desc_ptr, 32'h1000_0040);
    rd(2'd1, 0, 0, v); check("R2 active held", v & 1, 1);
    check("R2 dir updated", {31'b0, xfer_dir}, 1);

    // R9: completion
    pulse(walk_done);
    rd(2'd1, 0, 0, v); check("R9 done clears active", v, sts(0, 0, 0));
    wr(2'd0, 0, 0, 0);
    wr(2'd0, 0, 0, 1);
    check("R3 rekick", {31'b0, walk_kick}, 1);
    check("R3 reload", desc_ptr, 32'h2222_0000);
    pulse(walk_underrun);
    rd(2'd1, 0, 0, v); check("R9 underrun", v, sts(0, 1, 0));

    // R8: status write cannot touch active
    wr(2'd0, 0, 0, 0);
    wr(2'd0, 0, 0, 1);
    wr(2'd1, 0, 0, 32'h0000_00FE);
    rd(2'd1, 0, 0, v); check("R8 w1c keeps active", v, sts(1, 0, 0));

    // R4: stop waits for the in-flight transfer; restart during the wait
    @(negedge clk); xfer_busy = 1'b1;
    wr(2'd0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rd(2'd1, 0, 0, v); check("R4 held while busy", v & 1, 1);
    wr(2'd2, 0, 2, 32'h3333_0008);
    wr(2'd0, 0, 0, 1);
    check("R3 no kick when active", {31'b0, walk_kick}, 0);
    check("R3 reload while active", desc_ptr, 32'h3333_0008);
    xfer_busy = 1'b0;
    @(negedge clk);
    rd(2'd1, 0, 0, v); check("R4 restart cancels stop", v & 1, 1);
    xfer_busy = 1'b1;
    wr(2'd0, 0, 0, 0);
    @(negedge clk);
    rd(2'd1, 0, 0, v); check("R4 pending", v & 1, 1);
    xfer_busy = 1'b0;
    @(negedge clk);
    rd(2'd1, 0, 0, v); check("R4 drained", v & 1, 0);

    // R7: interrupt forwarding
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk);
    check("R7 host high", {31'b0, host_irq}, 1);
    rd(2'd1, 0, 0, v); check("R7 int set", v, sts(0, 0, 1));
    wr(2'd1, 0, 0, 32'h4);
    rd(2'd1, 0, 0, v); check("R8 int cleared", v, sts(0, 0, 0));
    dev_irq = 1'b0;
    @(negedge clk);
    check("R7 host low", {31'b0, host_irq}, 0);
    rd(2'd1, 0, 0, v); check("R7 fall no status", v, sts(0, 0, 0));
    dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    @(negedge clk);
    rd(2'd1, 0, 0, v); check("R7 latched after fall", v, sts(0, 0, 1));
    // R8: clear and rise in the same cycle, set wins
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h4; dev_irq = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd1, 0, 0, v); check("R8 set beats clear", v, sts(0, 0, 1));

    // R10: reset from a busy state
    wr(2'd0, 0, 0, 32'h9);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    rd(2'd0, 0, 2, v); check("R10 cmd after reset", v, 0);
    rd(2'd1, 0, 2, v); check("R10 status after reset", v, 0);
    rd(2'd2, 0, 2, v); check("R10 base after reset", v, 0);
    check("R10 ptr after reset", desc_ptr, 0);
    check("R10 host after reset", {31'b0, host_irq}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule